// File: doc/BRIEF.md
# Register-Port Micro Core

This block is a small single-issue processor core. Each instruction finishes in one clock cycle. It fetches from an instruction port and reaches a data port for stack traffic. It executes a fixed integer subset: AND, OR, ADD immediate, AND immediate, OR immediate, word load, word store, BEQ, BNE and JAL. The usual assembler shorthands reduce to these: load-immediate, register move, branch-if-nonzero and plain jump. Any other encoding stops the core.

General-purpose I/O sits inside one ordinary integer register, not behind an address decoder. The hardware copies an external sensor pin into the low bit of that register on every clock. A second bit of the same register, registered once more, drives an actuator pin. Software reads the sensor by masking the register. It drives the actuator by clearing and setting the output bit with ordinary logic instructions. A typical control loop holds the actuator high while the sensor is low and releases it when the sensor rises.

Top module: `gpio_reg_core`

## Requirements
- R1: While reset is low, imem_addr equals START_ADDR (default 0x00010054), actuator_o is 0, and fault_illegal_o and fault_align_o are 0.
- R2: ADDI, ANDI, ORI (opcode 0010011, funct3 000/111/110), AND and OR (opcode 0110011, funct7 0, funct3 111/110), LW (0000011, funct3 010) and SW (0100011, funct3 010) execute with RV32I semantics. Immediates are sign-extended.
- R3: BEQ and BNE (opcode 1100011, funct3 000/001) go to pc+offset when taken and to pc+4 otherwise. JAL (1101111) goes to pc+offset and writes pc+4 to rd.
- R4: Register x0 reads as zero, and writes to it are discarded.
- R5: On every clock, bit 0 of register x30 takes the level of sensor_i. An instruction writing x30 sets only bits 31..1, and bit 0 still takes the pin.
- R6: actuator_o is a registered copy of bit 1 of x30, one clock after that bit changes. Reset clears x30.
- R7: Running the sensor loop program, actuator_o settles to the inverse of sensor_i within 40 cycles. The stored copy of x30 then reads 1 when the sensor is high and 2 when it is low.
- R8: A LW or SW whose address has bits 1..0 not zero makes no memory access and no register write. It sets the sticky fault_align_o and halts the core.
- R9: An unsupported encoding does not execute. It sets the sticky fault_illegal_o, and imem_addr then stays fixed at that instruction's address.
- R10: dmem_we is high only for an aligned SW in a core that has not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word, valid in the same cycle |
| dmem_addr | output | 32 | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the clock edge |
| dmem_rdata | input | 32 | Load data, valid in the same cycle |
| sensor_i | input | 1 | Sensor level |
| actuator_o | output | 1 | Actuator drive |
| fault_align_o | output | 1 | Sticky misaligned-access fault |
| fault_illegal_o | output | 1 | Sticky unsupported-instruction fault |

## Verification
The assertions take for granted that both memory ports answer combinationally in the cycle the address is shown, and that once a fault flag rises nothing outside the core restarts it except reset. The bench keeps within these limits. Its memory models read without latency and write only at the clock edge. It changes the sensor pin only at falling edges, far enough apart that the loop program completes several passes between changes. Each program is loaded while reset is held, so no fetch sees a partly written image.

// File: rtl/grc_pkg.sv
package grc_pkg;

  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef struct packed {
    alu_op_e         alu;
    logic            use_imm;
    logic            reg_we;
    logic            is_load;
    logic            is_store;
    logic            is_branch;
    logic            br_ne;
    logic            is_jal;
    logic            illegal;
    logic [4:0]      rd;
    logic [4:0]      rs1;
    logic [4:0]      rs2;
    logic [XLEN-1:0] imm;
  } dec_t;

endpackage

// File: rtl/grc_decode.sv
module grc_decode
  import grc_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    dec         = '0;
    dec.alu     = ALU_ADD;
    dec.rd      = instr[11:7];
    dec.rs1     = instr[19:15];
    dec.rs2     = instr[24:20];
    unique case (opc)
      OPC_IMM: begin
        dec.use_imm = 1'b1;
        dec.reg_we  = 1'b1;
        dec.imm     = {{(XLEN-12){instr[31]}}, instr[31:20]};
        unique case (f3)
          3'b000:  dec.alu = ALU_ADD;
          3'b111:  dec.alu = ALU_AND;
          3'b110:  dec.alu = ALU_OR;
          default: dec.illegal = 1'b1;
        endcase
      end
      OPC_REG: begin
        dec.reg_we = 1'b1;
        if (f7 != 7'd0) begin
          dec.illegal = 1'b1;
        end else begin
          unique case (f3)
            3'b111:  dec.alu = ALU_AND;
            3'b110:  dec.alu = ALU_OR;
            default: dec.illegal = 1'b1;
          endcase
        end
      end
      OPC_LOAD: begin
        dec.is_load = 1'b1;
        dec.reg_we  = 1'b1;
        dec.use_imm = 1'b1;
        dec.imm     = {{(XLEN-12){instr[31]}}, instr[31:20]};
        dec.illegal = (f3 != 3'b010);
      end
      OPC_STORE: begin
        dec.is_store = 1'b1;
        dec.use_imm  = 1'b1;
        dec.imm      = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
        dec.illegal  = (f3 != 3'b010);
      end
      OPC_BRANCH: begin
        dec.is_branch = 1'b1;
        dec.br_ne     = f3[0];
        dec.imm       = {{(XLEN-13){instr[31]}}, instr[31], instr[7],
                         instr[30:25], instr[11:8], 1'b0};
        dec.illegal   = (f3[2:1] != 2'b00);
      end
      OPC_JAL: begin
        dec.is_jal = 1'b1;
        dec.reg_we = 1'b1;
        dec.imm    = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12],
                      instr[20], instr[30:21], 1'b0};
      end
      default: dec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/grc_regfile.sv
module grc_regfile
  import grc_pkg::*;
#(
  parameter int unsigned NREG      = 32,
  parameter int unsigned IO_REG    = 30,
  parameter int unsigned SENSE_BIT = 0,
  parameter int unsigned ACT_BIT   = 1,
  localparam int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [XLEN-1:0]  wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [XLEN-1:0]  rdata_a,
  output logic [XLEN-1:0]  rdata_b,
  input  logic             sense_i,
  output logic             io_act
);

  logic [XLEN-1:0] regs [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign regs[r] = '0;
    end else if (r == IO_REG) begin : g_io
      logic [XLEN-1:0] q;
      logic [XLEN-1:0] d;
      always_comb begin
        d = q;
        if (we && (waddr == IDX_W'(r))) d = wdata;
        d[SENSE_BIT] = sense_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign regs[r] = q;
    end else begin : g_gp
      logic [XLEN-1:0] q;
      logic            en;
      assign en = we && (waddr == IDX_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata;
      end
      assign regs[r] = q;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign io_act  = regs[IO_REG][ACT_BIT];

endmodule

// File: rtl/grc_exec.sv
module grc_exec
  import grc_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] alu_res,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link
);

  logic [XLEN-1:0] opb;
  logic            taken;

  assign opb = dec.use_imm ? dec.imm : src_b;

  always_comb begin
    unique case (dec.alu)
      ALU_AND: alu_res = src_a & opb;
      ALU_OR:  alu_res = src_a | opb;
      default: alu_res = src_a + opb;
    endcase
  end

  assign mem_addr = src_a + dec.imm;
  assign link     = pc + XLEN'(4);
  assign taken    = dec.is_branch && ((src_a == src_b) ^ dec.br_ne);
  assign next_pc  = (dec.is_jal || taken) ? pc + dec.imm : link;

endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core
  import grc_pkg::*;
#(
  parameter int unsigned     NREG       = 32,
  parameter int unsigned     IO_REG     = 30,
  parameter int unsigned     SENSE_BIT  = 0,
  parameter int unsigned     ACT_BIT    = 1,
  parameter logic [XLEN-1:0] START_ADDR = 32'h0001_0054
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  input  logic            sensor_i,
  output logic            actuator_o,
  output logic            fault_align_o,
  output logic            fault_illegal_o
);

  localparam int unsigned IDX_W = $clog2(NREG);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // state
  logic [XLEN-1:0] pc_q, pc_d;
  logic            ill_q, ill_d;
  logic            aln_q, aln_d;
  logic            act_q, act_d;

  dec_t            dec;
  logic [XLEN-1:0] src_a, src_b, alu_res, mem_addr, next_pc, link, wb_data;
  logic            halted, mis, fault, advance, rf_we, io_act;

  grc_decode u_dec (
    .instr (imem_rdata),
    .dec   (dec)
  );

  grc_regfile #(
    .NREG      (NREG),
    .IO_REG    (IO_REG),
    .SENSE_BIT (SENSE_BIT),
    .ACT_BIT   (ACT_BIT)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (rf_we),
    .waddr   (dec.rd[IDX_W-1:0]),
    .wdata   (wb_data),
    .raddr_a (dec.rs1[IDX_W-1:0]),
    .raddr_b (dec.rs2[IDX_W-1:0]),
    .rdata_a (src_a),
    .rdata_b (src_b),
    .sense_i (sensor_i),
    .io_act  (io_act)
  );

  grc_exec u_exe (
    .dec      (dec),
    .pc       (pc_q),
    .src_a    (src_a),
    .src_b    (src_b),
    .alu_res  (alu_res),
    .mem_addr (mem_addr),
    .next_pc  (next_pc),
    .link     (link)
  );

  // next-state logic
  always_comb begin
    halted  = ill_q | aln_q;
    mis     = (dec.is_load | dec.is_store) & (mem_addr[1:0] != 2'b00) & ~dec.illegal;
    fault   = dec.illegal | mis;
    advance = ~halted & ~fault;
    rf_we   = advance & dec.reg_we;

    if (dec.is_jal)       wb_data = link;
    else if (dec.is_load) wb_data = dmem_rdata;
    else                  wb_data = alu_res;

    pc_d  = advance ? next_pc : pc_q;
    ill_d = ill_q | (~halted & dec.illegal);
    aln_d = aln_q | (~halted & mis);
    act_d = io_act;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= START_ADDR;
      ill_q <= 1'b0;
      aln_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ill_q <= ill_d;
      aln_q <= aln_d;
      act_q <= act_d;
    end
  end

  assign imem_addr       = pc_q;
  assign dmem_addr       = mem_addr;
  assign dmem_wdata      = src_b;
  assign dmem_we         = advance & dec.is_store;
  assign actuator_o      = act_q;
  assign fault_align_o   = aln_q;
  assign fault_illegal_o = ill_q;

endmodule

// File: rtl/grc_chk.sv
module grc_chk
  import grc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] dmem_addr,
  input logic            dmem_we,
  input logic            actuator_o,
  input logic            fault_align_o,
  input logic            fault_illegal_o
);

  // R10
  store_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (dmem_addr[1:0] == 2'b00));

  // R10
  no_store_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_align_o || fault_illegal_o) |-> !dmem_we);

  // R9
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_illegal_o |=> fault_illegal_o);

  // R9
  illegal_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_illegal_o |=> $stable(imem_addr));

  // R8
  align_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_align_o |=> fault_align_o);

  // R8
  align_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_align_o |=> $stable(imem_addr));

  // R6
  act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_align_o || fault_illegal_o) |=> $stable(actuator_o));

endmodule

bind gpio_reg_core grc_chk u_grc_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .imem_addr       (imem_addr),
  .dmem_addr       (dmem_addr),
  .dmem_we         (dmem_we),
  .actuator_o      (actuator_o),
  .fault_align_o   (fault_align_o),
  .fault_illegal_o (fault_illegal_o)
);

// File: tb/tb_gpio_reg_core.sv
module tb_gpio_reg_core;

  localparam logic [31:0] START = 32'h0001_0054;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, sensor_i = 1'b0;
  logic        actuator_o, fault_align_o, fault_illegal_o;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic act; logic [31:0] snap; logic [31:0] samp; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  gpio_reg_core #(.START_ADDR(START)) dut (
    .clk (clk), .rst_n (rst_n),
    .imem_addr (imem_addr), .imem_rdata (imem_rdata),
    .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata),
    .dmem_we (dmem_we), .dmem_rdata (dmem_rdata),
    .sensor_i (sensor_i), .actuator_o (actuator_o),
    .fault_align_o (fault_align_o), .fault_illegal_o (fault_illegal_o)
  );

  logic [31:0] ioff;
  assign ioff       = (imem_addr - START) >> 2;
  assign imem_rdata = imem[ioff[5:0]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // encoders
  function automatic logic [31:0] e_i(logic [31:0] imm, logic [31:0] rs1, logic [2:0] f3,
                                      logic [31:0] rd, logic [6:0] op);
    return {imm[11:0], rs1[4:0], f3, rd[4:0], op};
  endfunction
  function automatic logic [31:0] e_r(logic [31:0] rs2, logic [31:0] rs1, logic [2:0] f3,
                                      logic [31:0] rd);
    return {7'd0, rs2[4:0], rs1[4:0], f3, rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] e_s(logic [31:0] imm, logic [31:0] rs2, logic [31:0] rs1);
    return {imm[11:5], rs2[4:0], rs1[4:0], 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(logic [31:0] imm, logic [31:0] rs2, logic [31:0] rs1,
                                      logic [2:0] f3);
    return {imm[12], imm[10:5], rs2[4:0], rs1[4:0], f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(logic [31:0] imm, logic [31:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'b1101111};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  // driver: changes the sensor and queues the settled result
  task automatic drive_sensor(logic v);
    exp_t e;
    @(negedge clk);
    sensor_i = v;
    e.act  = ~v;
    e.snap = v ? 32'd1 : 32'd2;
    e.samp = {31'd0, v};
    sb_q.push_back(e);
    repeat (60) @(negedge clk);
  endtask

  // monitor: pops an expectation and compares once the loop has settled
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        repeat (40) @(negedge clk);
        check("R7 actuator follows inverted sensor", {31'd0, actuator_o}, {31'd0, e.act});
        check("R7 stored x30 copy (mv/or, R5 bit0)", dmem[54], e.snap);
        check("R2 andi/sw/lw sensor sample", dmem[53], e.samp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // ---------- program A: sensor control loop ----------
    clear_mem();
    imem[0]  = e_i(256, 0, 3'b000, 2, 7'b0010011);        // li sp,256
    imem[1]  = e_i(-48, 2, 3'b000, 2, 7'b0010011);        // addi sp,sp,-48
    imem[2]  = e_i(1, 30, 3'b111, 15, 7'b0010011);        // andi x15,x30,1
    imem[3]  = e_s(4, 15, 2);                             // sw x15,4(sp)
    imem[4]  = e_i(4, 2, 3'b010, 14, 7'b0000011);         // lw x14,4(sp)
    imem[5]  = e_i(-3, 0, 3'b000, 13, 7'b0010011);        // li x13,-3
    imem[6]  = e_r(13, 30, 3'b111, 13);                   // and x13,x30,x13
    imem[7]  = e_b(8, 0, 14, 3'b001);                     // bnez x14,+8
    imem[8]  = e_i(2, 13, 3'b110, 13, 7'b0010011);        // ori x13,x13,2
    imem[9]  = e_r(0, 13, 3'b110, 30);                    // or x30,x13,x0
    imem[10] = e_i(0, 30, 3'b000, 11, 7'b0010011);        // mv x11,x30
    imem[11] = e_s(8, 11, 2);                             // sw x11,8(sp)
    imem[12] = e_j(-40, 0);                               // j loop
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 reset pc", imem_addr, START);
    check("R1 reset actuator", {31'd0, actuator_o}, 32'd0);
    check("R1 reset faults", {30'd0, fault_align_o, fault_illegal_o}, 32'd0);
    release_reset();
    drive_sensor(1'b0);
    drive_sensor(1'b1);
    drive_sensor(1'b0);
    drive_sensor(1'b1);
    drive_sensor(1'b1);
    drive_sensor(1'b0);
    check("R2 loop raises no fault", {30'd0, fault_align_o, fault_illegal_o}, 32'd0);

    // ---------- program B: branches, x0, misaligned store ----------
    hold_reset();
    clear_mem();
    sensor_i = 1'b0;
    dmem[16] = 32'hDEAD;
    dmem[17] = 32'h1111;
    dmem[19] = 32'h2222;
    dmem[22] = 32'h3333;
    imem[0]  = e_i(64, 0, 3'b000, 2, 7'b0010011);         // li sp,64
    imem[1]  = e_i(5, 0, 3'b000, 0, 7'b0010011);          // addi x0,x0,5
    imem[2]  = e_s(0, 0, 2);                              // sw x0,0(sp)
    imem[3]  = e_b(8, 0, 0, 3'b000);                      // beq x0,x0,+8
    imem[4]  = e_s(4, 2, 2);                              // skipped
    imem[5]  = e_i(7, 0, 3'b000, 5, 7'b0010011);          // li x5,7
    imem[6]  = e_s(8, 5, 2);                              // sw x5,8(sp)
    imem[7]  = e_b(8, 0, 5, 3'b001);                      // bne x5,x0,+8
    imem[8]  = e_s(12, 5, 2);                             // skipped
    imem[9]  = e_i(8, 2, 3'b010, 6, 7'b0000011);          // lw x6,8(sp)
    imem[10] = e_i(1, 6, 3'b000, 6, 7'b0010011);          // addi x6,x6,1
    imem[11] = e_s(16, 6, 2);                             // sw x6,16(sp)
    imem[12] = e_s(2, 6, 2);                              // misaligned sw
    imem[13] = e_s(24, 6, 2);                             // never reached
    release_reset();
    repeat (40) @(negedge clk);
    check("R4 x0 reads zero after write", dmem[16], 32'h0);
    check("R3 beq taken skips", dmem[17], 32'h1111);
    check("R2 addi/sw", dmem[18], 32'd7);
    check("R3 bne taken skips", dmem[19], 32'h2222);
    check("R2 lw then addi", dmem[20], 32'd8);
    check("R8 misalign flag", {31'd0, fault_align_o}, 32'd1);
    check("R8 no illegal flag", {31'd0, fault_illegal_o}, 32'd0);
    check("R8 halted pc", imem_addr, START + 32'd48);
    check("R10 no later store", dmem[22], 32'h3333);

    // ---------- program C: sensor override, actuator, illegal ----------
    hold_reset();
    clear_mem();
    sensor_i = 1'b0;
    dmem[9]  = 32'h4444;
    imem[0]  = e_i(3, 0, 3'b110, 30, 7'b0010011);         // ori x30,x0,3
    imem[1]  = e_i(0, 30, 3'b000, 7, 7'b0010011);         // mv x7,x30
    imem[2]  = e_s(32, 7, 0);                             // sw x7,32(x0)
    imem[3]  = 32'hFFFF_FFFF;                             // unsupported
    imem[4]  = e_s(36, 7, 0);                             // never reached
    release_reset();
    repeat (20) @(negedge clk);
    check("R5 pin overrides bit0 write", dmem[8], 32'd2);
    check("R6 actuator from x30 bit1", {31'd0, actuator_o}, 32'd1);
    check("R9 illegal flag", {31'd0, fault_illegal_o}, 32'd1);
    check("R9 pc stuck", imem_addr, START + 32'd12);
    check("R9 no execution past fault", dmem[9], 32'h4444);
    check("R8 no align flag", {31'd0, fault_align_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule